// File: doc/BRIEF.md
# Nonvolatile Store and Recall Controller

This block sits between the up/down position counter of a digital trimmer and an abstract nonvolatile memory. It decides when the present position is written to memory and when the saved value is brought back. After reset it reads the memory once, hands the value to the counter through a one-cycle load strobe, and only then allows the up/down buttons to step the counter.

A single active-low store pin has two uses. The block reads the pin level at the moment the recalled value arrives. If the pin is low at that point, it is taken as tied low: autostore mode. In this mode a rising power-fail flag, with the pin low, triggers one write of the position. If the pin is high at that point, it is taken as a push button: manual mode. In this mode every debounced press writes the position once. Stepping is blocked while the button is held and until that write is done.

The memory port has two handshakes. A write request lasts one cycle, and the memory must raise busy in the next cycle and hold it until the write is complete. A read request is held until a one-cycle valid arrives with the data. The button debounce window is a parameter in clock cycles.

Top module: `nv_keeper`

## Requirements
- R1: After reset the block holds `mem_rd_req` high until `mem_rd_valid`. In the next cycle it pulses `load_valid` for one cycle, with `load_value` equal to the data that came with the valid. During reset, `mem_rd_req`, `mem_wr_req`, `step_enable` and `load_valid` are all 0.
- R2: `step_enable` stays 0 from reset through the `load_valid` cycle. It is 1 in the cycle after `load_valid` when no store is pending and the button is not held.
- R3: The mode is chosen from the synchronized store-pin level in the cycle the recall data arrives. If the level is low, `mode_auto` is 1; if it is high, `mode_auto` is 0. The mode then holds until the next reset.
- R4: In autostore mode, a 0-to-1 change of `pwr_fail` while the store pin is low raises `mem_wr_req` in the next cycle. This is far inside the 2 ms budget for finishing a store.
- R5: In manual mode, each press held low for at least `DB_CYCLES` cycles (after synchronization) yields exactly one write request. A low shorter than that yields none.
- R6: In manual mode, `step_enable` is 0 while the debounced pin is low. It also stays 0 until the write started by the press has completed (busy low). In autostore mode, a low pin does not block stepping.
- R7: A press or a power-fail edge that comes while a write is outstanding is dropped. `mem_wr_req` is never 1 while `mem_wr_busy` is 1.
- R8: None of the following causes a write: changes of `pos_in`, `pwr_fail` in manual mode, or a pin held low in autostore mode. Memory changes only through a store.
- R9: `mem_wr_req` is never high for two cycles in a row. `mem_wr_data` equals `pos_in` as it was at the clock edge before the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| store_pin_n | input | 1 | Raw store pin, active low, asynchronous |
| pwr_fail | input | 1 | Supply-falling indication, synchronous to clk |
| pos_in | input | POS_W | Current wiper position from the counter |
| load_valid | output | 1 | One-cycle strobe to load the recalled value |
| load_value | output | POS_W | Recalled position |
| step_enable | output | 1 | Up/down stepping allowed |
| mode_auto | output | 1 | 1 = autostore mode, 0 = manual store mode |
| mem_wr_req | output | 1 | One-cycle write request |
| mem_wr_data | output | POS_W | Position to be written |
| mem_wr_busy | input | 1 | Write in progress, high from the cycle after the request |
| mem_rd_req | output | 1 | Read request, held until valid |
| mem_rd_valid | input | 1 | One-cycle read data valid |
| mem_rd_data | input | POS_W | Read data |

## Verification
The hardest case to reach is a second store trigger that lands while a write is still outstanding. A press needs a full debounce window on both the release and the new low, so a normal short write finishes before any new press can register. The bench stretches its memory model's busy time to 60 cycles. It then releases and presses again inside that window, and does the same with a second power-fail edge in autostore mode. Finally it resets with the pin low to confirm that the position saved by autostore is the one recalled.

// File: rtl/nvk_pkg.sv
package nvk_pkg;
  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_READ,
    ST_IDLE,
    ST_WRITE,
    ST_BUSY
  } nvk_state_e;
endpackage

// File: rtl/nvk_sync.sv
// Multi-stage synchronizer; also used as a reset release synchronizer.
module nvk_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/nvk_debounce.sv
// Level filter: the output follows the input once it has differed for
// DB_CYCLES consecutive cycles. press pulses for one cycle on a 1->0 change.
module nvk_debounce #(
  parameter int DB_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic level,
  output logic press
);
  localparam int CNT_W = $clog2(DB_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lvl_q, lvl_d;
  logic             press_q, press_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (raw == lvl_q) begin
      cnt_d = '0;
    end else if (cnt_q == CNT_W'(DB_CYCLES - 1)) begin
      lvl_d = raw;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    press_d = lvl_q & ~lvl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      lvl_q   <= 1'b1;
      press_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      lvl_q   <= lvl_d;
      press_q <= press_d;
    end
  end

  assign level = lvl_q;
  assign press = press_q;
endmodule

// File: rtl/nvk_seq.sv
// Recall / store sequencer.
module nvk_seq
  import nvk_pkg::*;
#(
  parameter int POS_W         = 8,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_lvl,
  input  logic             pin_db,
  input  logic             press,
  input  logic             pwr_fail,
  input  logic [POS_W-1:0] pos_in,
  input  logic             wr_busy,
  input  logic             rd_valid,
  input  logic [POS_W-1:0] rd_data,
  output logic             rd_req,
  output logic             wr_req,
  output logic [POS_W-1:0] wr_data,
  output logic             load_valid,
  output logic [POS_W-1:0] load_value,
  output logic             step_enable,
  output logic             mode_auto
);
  localparam int SET_W = $clog2(SETTLE_CYCLES + 1);

  nvk_state_e       state_q, state_d;
  logic [SET_W-1:0] set_cnt_q, set_cnt_d;
  logic             pwr_prev_q;
  logic [POS_W-1:0] wr_data_q, wr_data_d;
  logic             load_valid_q, load_valid_d;
  logic [POS_W-1:0] load_value_q, load_value_d;
  logic             mode_auto_q, mode_auto_d;
  logic             pwr_rise, auto_trig, man_trig;

  assign pwr_rise  = pwr_fail & ~pwr_prev_q;
  assign auto_trig = mode_auto_q & pwr_rise & ~pin_lvl;
  assign man_trig  = ~mode_auto_q & press;

  always_comb begin
    state_d      = state_q;
    set_cnt_d    = set_cnt_q;
    wr_data_d    = wr_data_q;
    load_valid_d = 1'b0;
    load_value_d = load_value_q;
    mode_auto_d  = mode_auto_q;
    case (state_q)
      ST_SETTLE: begin
        if (set_cnt_q == SET_W'(SETTLE_CYCLES - 1)) state_d = ST_READ;
        else set_cnt_d = set_cnt_q + 1'b1;
      end
      ST_READ: begin
        if (rd_valid) begin
          state_d      = ST_IDLE;
          load_valid_d = 1'b1;
          load_value_d = rd_data;
          mode_auto_d  = ~pin_lvl;
        end
      end
      ST_IDLE: begin
        if ((auto_trig | man_trig) && !wr_busy) begin
          state_d   = ST_WRITE;
          wr_data_d = pos_in;
        end
      end
      ST_WRITE: state_d = ST_BUSY;
      ST_BUSY:  if (!wr_busy) state_d = ST_IDLE;
      default:  state_d = ST_SETTLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_SETTLE;
      set_cnt_q    <= '0;
      pwr_prev_q   <= 1'b0;
      wr_data_q    <= '0;
      load_valid_q <= 1'b0;
      load_value_q <= '0;
      mode_auto_q  <= 1'b0;
    end else begin
      state_q      <= state_d;
      set_cnt_q    <= set_cnt_d;
      pwr_prev_q   <= pwr_fail;
      wr_data_q    <= wr_data_d;
      load_valid_q <= load_valid_d;
      load_value_q <= load_value_d;
      mode_auto_q  <= mode_auto_d;
    end
  end

  assign rd_req      = (state_q == ST_READ);
  assign wr_req      = (state_q == ST_WRITE);
  assign wr_data     = wr_data_q;
  assign load_valid  = load_valid_q;
  assign load_value  = load_value_q;
  assign mode_auto   = mode_auto_q;
  assign step_enable = (state_q == ST_IDLE) && !load_valid_q &&
                       (mode_auto_q || pin_db);
endmodule

// File: rtl/nv_keeper.sv
module nv_keeper #(
  parameter int POS_W         = 8,
  parameter int DB_CYCLES     = 3000000,
  parameter int SYNC_STAGES   = 2,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_pin_n,
  input  logic             pwr_fail,
  input  logic [POS_W-1:0] pos_in,
  output logic             load_valid,
  output logic [POS_W-1:0] load_value,
  output logic             step_enable,
  output logic             mode_auto,
  output logic             mem_wr_req,
  output logic [POS_W-1:0] mem_wr_data,
  input  logic             mem_wr_busy,
  output logic             mem_rd_req,
  input  logic             mem_rd_valid,
  input  logic [POS_W-1:0] mem_rd_data
);
  logic rst_int_n;
  logic pin_lvl;
  logic pin_db;
  logic press;

  nvk_sync #(.STAGES(2), .RESET_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  nvk_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n), .d(store_pin_n), .q(pin_lvl)
  );

  nvk_debounce #(.DB_CYCLES(DB_CYCLES)) u_db (
    .clk(clk), .rst_n(rst_int_n), .raw(pin_lvl), .level(pin_db), .press(press)
  );

  nvk_seq #(.POS_W(POS_W), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .pin_lvl(pin_lvl), .pin_db(pin_db), .press(press),
    .pwr_fail(pwr_fail), .pos_in(pos_in),
    .wr_busy(mem_wr_busy), .rd_valid(mem_rd_valid), .rd_data(mem_rd_data),
    .rd_req(mem_rd_req), .wr_req(mem_wr_req), .wr_data(mem_wr_data),
    .load_valid(load_valid), .load_value(load_value),
    .step_enable(step_enable), .mode_auto(mode_auto)
  );
endmodule

// File: rtl/nv_keeper_chk.sv
module nv_keeper_chk #(
  parameter int POS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_fail,
  input logic [POS_W-1:0] pos_in,
  input logic             pin_lvl,
  input logic             load_valid,
  input logic [POS_W-1:0] load_value,
  input logic             step_enable,
  input logic             mode_auto,
  input logic             mem_wr_req,
  input logic [POS_W-1:0] mem_wr_data,
  input logic             mem_wr_busy,
  input logic             mem_rd_req,
  input logic             mem_rd_valid,
  input logic [POS_W-1:0] mem_rd_data
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (load_valid) seen_q <= 1'b1;
  end

  assert_load_from_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> ($past(mem_rd_valid) && load_value == $past(mem_rd_data)));

  assert_recall_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step_enable |-> seen_q);

  assert_no_step_in_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_req && step_enable));

  assert_auto_prompt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwr_fail) && mode_auto && !pin_lvl && step_enable && !mem_wr_busy)
      |=> mem_wr_req);

  assert_no_req_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !mem_wr_busy);

  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |=> !mem_wr_req);

  assert_data_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> mem_wr_data == $past(pos_in));
endmodule

bind nv_keeper nv_keeper_chk #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .pos_in(pos_in),
  .pin_lvl(pin_lvl), .load_valid(load_valid), .load_value(load_value),
  .step_enable(step_enable), .mode_auto(mode_auto),
  .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data),
  .mem_wr_busy(mem_wr_busy), .mem_rd_req(mem_rd_req),
  .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
);

// File: tb/nv_keeper_test.sv
module nv_keeper_test;
  localparam int DB = 8;

  logic       clk;
  logic       rst_n;
  logic       pin_n;
  logic       pwr_fail;
  logic [7:0] pos;
  logic       load_valid;
  logic [7:0] load_value;
  logic       step_enable;
  logic       mode_auto;
  logic       wr_req;
  logic [7:0] wr_data;
  logic       wr_busy;
  logic       rd_req;
  logic       rd_valid;
  logic [7:0] rd_data;

  // memory model state
  logic [7:0] mem_q;
  int         wr_count;
  int         busy_len;
  int         bcnt;
  int         rd_cnt;
  logic       rd_started;

  int total;
  int bad;

  nv_keeper #(.POS_W(8), .DB_CYCLES(DB)) uut (
    .clk(clk), .rst_n(rst_n), .store_pin_n(pin_n), .pwr_fail(pwr_fail),
    .pos_in(pos), .load_valid(load_valid), .load_value(load_value),
    .step_enable(step_enable), .mode_auto(mode_auto),
    .mem_wr_req(wr_req), .mem_wr_data(wr_data), .mem_wr_busy(wr_busy),
    .mem_rd_req(rd_req), .mem_rd_valid(rd_valid), .mem_rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign rd_data = mem_q;

  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (rd_req && !rd_started) begin
      rd_started <= 1'b1;
      rd_cnt     <= 2;
    end else if (rd_cnt != 0) begin
      rd_cnt <= rd_cnt - 1;
      if (rd_cnt == 1) rd_valid <= 1'b1;
    end
    if (!rd_req) rd_started <= 1'b0;

    if (wr_req) begin
      mem_q    <= wr_data;
      wr_count <= wr_count + 1;
      wr_busy  <= 1'b1;
      bcnt     <= busy_len;
    end else if (bcnt > 1) begin
      bcnt <= bcnt - 1;
    end else if (bcnt == 1) begin
      wr_busy <= 1'b0;
      bcnt    <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic pin, input logic [7:0] exp_val);
    bit early;
    bit got;
    rst_n = 1'b0;
    pin_n = pin;
    wait_cyc(4);
    chk(rd_req == 0 && wr_req == 0, "R1 reset mem requests", {rd_req, wr_req}, 0);
    chk(step_enable == 0 && load_valid == 0, "R1 reset outputs",
        {step_enable, load_valid}, 0);
    rst_n = 1'b1;
    early = 0;
    got   = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (load_valid) begin
        got = 1;
        break;
      end
      if (step_enable) early = 1;
    end
    chk(got, "R1 load strobe seen", got, 1);
    chk(load_value == exp_val, "R1 recalled value", load_value, exp_val);
    chk(!early && !step_enable, "R2 no step before load", step_enable, 0);
    chk(mode_auto == !pin, "R3 mode chosen", mode_auto, !pin);
    @(negedge clk);
    chk(load_valid == 0, "R1 load strobe one cycle", load_valid, 0);
    chk(step_enable == 1, "R2 step after load", step_enable, 1);
  endtask

  // {position, low-time in cycles, expected writes}
  localparam logic [23:0] VECS [0:4] = '{
    {8'h11, 8'd20, 8'd1},
    {8'h22, 8'd4,  8'd0},
    {8'hFF, 8'd14, 8'd1},
    {8'h5A, 8'd3,  8'd0},
    {8'h00, 8'd30, 8'd1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int w0;
    logic [7:0] m0;
    total = 0;
    bad = 0;
    mem_q = 8'hA5;
    wr_count = 0;
    busy_len = 5;
    bcnt = 0;
    rd_cnt = 0;
    rd_started = 1'b0;
    rd_valid = 1'b0;
    wr_busy = 1'b0;
    pwr_fail = 1'b0;
    pos = 8'h00;
    rst_n = 1'b0;
    pin_n = 1'b1;

    // manual mode power-up
    do_reset(1'b1, 8'hA5);

    // vector walk: R5 presses and glitches, R8 position changes alone
    for (int v = 0; v < 5; v++) begin
      w0 = wr_count;
      m0 = mem_q;
      pos = VECS[v][23:16];
      wait_cyc(3);
      pin_n = 1'b0;
      wait_cyc(int'(VECS[v][15:8]));
      pin_n = 1'b1;
      wait_cyc(40);
      chk(wr_count - w0 == int'(VECS[v][7:0]), "R5 writes per press",
          wr_count - w0, int'(VECS[v][7:0]));
      if (VECS[v][7:0] != 0)
        chk(mem_q == VECS[v][23:16], "R9 stored position", mem_q, VECS[v][23:16]);
      else
        chk(mem_q == m0, "R8 memory kept", mem_q, m0);
    end

    // R6: step inhibit while held and until write done
    pos = 8'h44;
    pin_n = 1'b0;
    wait_cyc(14);
    chk(step_enable == 0, "R6 held button blocks step", step_enable, 0);
    wait_cyc(30);
    chk(step_enable == 0, "R6 still held", step_enable, 0);
    pin_n = 1'b1;
    wait_cyc(15);
    chk(step_enable == 1, "R6 step restored", step_enable, 1);

    // R8: power fail in manual mode stores nothing
    w0 = wr_count;
    pos = 8'h99;
    pwr_fail = 1'b1;
    wait_cyc(5);
    pwr_fail = 1'b0;
    wait_cyc(10);
    chk(wr_count == w0, "R8 manual pwr_fail ignored", wr_count - w0, 0);

    // R7: second press during a long write is dropped
    busy_len = 60;
    w0 = wr_count;
    pos = 8'h61;
    pin_n = 1'b0;
    wait_cyc(14);
    pin_n = 1'b1;
    wait_cyc(14);
    chk(step_enable == 0, "R6 blocked while write busy", step_enable, 0);
    pos = 8'h62;
    wait_cyc(2);
    pin_n = 1'b0;
    wait_cyc(14);
    pin_n = 1'b1;
    wait_cyc(100);
    chk(wr_count - w0 == 1, "R7 press during busy dropped", wr_count - w0, 1);
    chk(mem_q == 8'h61, "R7 first press value kept", mem_q, 8'h61);
    busy_len = 5;

    // autostore mode power-up
    mem_q = 8'h3C;
    do_reset(1'b0, 8'h3C);
    wait_cyc(30);
    chk(step_enable == 1, "R6 low pin no block in auto", step_enable, 1);
    chk(wr_count - w0 == 1, "R8 held pin in auto writes nothing", wr_count - w0, 1);

    // R4: power-fail edge stores promptly
    w0 = wr_count;
    pos = 8'h77;
    pwr_fail = 1'b1;
    @(negedge clk);
    chk(wr_req == 1, "R4 request next cycle", wr_req, 1);
    chk(wr_data == 8'h77, "R9 request data", wr_data, 8'h77);
    @(negedge clk);
    chk(wr_req == 0, "R9 single pulse", wr_req, 0);
    wait_cyc(10);
    pwr_fail = 1'b0;
    chk(mem_q == 8'h77 && wr_count - w0 == 1, "R4 autostore done", mem_q, 8'h77);

    // R7: second power-fail edge during long write dropped
    busy_len = 60;
    w0 = wr_count;
    pos = 8'h12;
    wait_cyc(2);
    pwr_fail = 1'b1;
    wait_cyc(5);
    pwr_fail = 1'b0;
    pos = 8'h13;
    wait_cyc(5);
    pwr_fail = 1'b1;
    wait_cyc(3);
    pwr_fail = 1'b0;
    wait_cyc(80);
    chk(wr_count - w0 == 1, "R7 pwr edge during busy dropped", wr_count - w0, 1);
    chk(mem_q == 8'h12, "R7 first autostore value", mem_q, 8'h12);
    busy_len = 5;

    // restore after power loss: recall the autostored value
    do_reset(1'b0, 8'h12);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule